// File: doc/BRIEF.md
# UART Control Register and Transmit-Empty Interrupt Front End

This block is the register and interrupt front end of a FIFO-buffered serial port. The CPU reaches four byte-wide registers through a simple read/write port. They are a control register, a prescaler select, a status register and a transmit trigger count. The control register holds the interrupt enables, the transmitter and receiver enables and a clock-mode field. The surrounding UART logic takes these fields straight from output pins. The prescaler select picks one of four divided rates. The block produces that rate as a single-cycle enable pulse for the external baud counter.

The block watches the fill level of the transmit FIFO and compares it with the programmed trigger count. While the FIFO holds fewer entries than the trigger count, the transmit-empty status flag sets. When transmit interrupts are enabled, the flag drives the transmit interrupt.

Software clears the flag with a two-step handshake. It must first read the status register and see the flag as 1. After that read, writing 0 clears the flag. A write of 0 without that read has no effect. If the FIFO is still below the trigger level when the flag is cleared, the flag sets again on the following cycle. A standby input forces the control register back to its reset value.

Top module: `sctl_top`

## Requirements
- R1: The prescaler select (register address 1, bits 1:0) resets to 00. Code 00 makes the tick output high on every cycle. Codes 01, 10 and 11 make the tick a one-cycle pulse once every 4, 16 and 64 cycles of a free-running counter.
- R2: The control register is at address 0 and resets to 0x00. Bit 7 is the transmit interrupt enable and bit 6 is the receive interrupt enable. Bit 5 is the transmitter enable and bit 4 is the receiver enable. Bits 1:0 are the clock mode. Each field appears on its own output pin one cycle after a write, and the register can be read at any time.
- R3: While standby is high, the control register is forced to 0x00 from the next clock edge on, and writes to it are ignored.
- R4: The transmit-empty flag (address 2, bit 0) becomes 1 on the clock edge after a cycle in which the FIFO level is below the trigger count.
- R5: The transmit interrupt output equals the transmit-empty flag AND the transmit interrupt enable, so it is 0 whenever that enable is 0.
- R6: A write of 0 to status bit 0 clears the flag only if the CPU has read the flag as 1 since the flag last went from 0 to 1. A write of 0 without such a read leaves the flag at 1, and a write of 1 has no effect.
- R7: If the FIFO level is still below the trigger count when the flag is cleared, the flag reads 0 for one cycle and is 1 again on the next edge. Re-arming then needs a fresh read.
- R8: Control register bits 3:2 always read as 0, whatever value is written to them.
- R9: The trigger count register (address 3, low $clog2(FIFO_DEPTH+1) bits) resets to FIFO_DEPTH/2, reads back what was written, and sets the compare threshold used by R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| standby | input | 1 | Forces the control register to reset while high |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (arms the flag clear) |
| regSel | input | 2 | Register address: 0 control, 1 prescaler, 2 status, 3 trigger |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for regSel, combinational |
| fifoLevel | input | LVL_W | Current transmit FIFO fill level |
| txIrq | output | 1 | Transmit interrupt request |
| txIntEn | output | 1 | Transmit interrupt enable field |
| rxIntEn | output | 1 | Receive interrupt enable field |
| txEn | output | 1 | Transmitter enable field |
| rxEn | output | 1 | Receiver enable field |
| clkMode | output | 2 | Clock mode field |
| baudTick | output | 1 | Prescaler enable pulse |
| txEmptyFlag | output | 1 | Transmit-empty status flag |

## Verification
The assertions assume that fifoLevel never exceeds FIFO_DEPTH. They also assume that a status write with bit 0 low is the only event that may drop the flag. This lets them state when the flag must set and when it must hold without modelling the read-arm state. The stimulus drives levels only in the range 0 to FIFO_DEPTH and changes inputs on the falling edge. It also empties the flag through the legal read-then-write sequence before each vector of the sweep over trigger count and level, so every vector starts from a known, unarmed state.

// File: rtl/sctl_pkg.sv
package sctl_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_PRESC = 2'd1,
    SEL_STAT  = 2'd2,
    SEL_TRIG  = 2'd3
  } regSel_e;

  // Strobes from the control module to the datapath
  typedef struct packed {
    logic wrCtrl;
    logic wrPresc;
    logic wrTrig;
  } strobe_t;
endpackage

// File: rtl/sctl_control.sv
module sctl_control
  import sctl_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic [1:0] regSel,
  input  logic       wrBit0,
  input  logic       belowTrig,
  output strobe_t    strb,
  output logic       txFlag
);
  logic armed;
  logic statWr;
  logic statRd;
  logic clrReq;

  assign strb.wrCtrl  = wrEn && (regSel == SEL_CTRL);
  assign strb.wrPresc = wrEn && (regSel == SEL_PRESC);
  assign strb.wrTrig  = wrEn && (regSel == SEL_TRIG);

  assign statWr = wrEn && (regSel == SEL_STAT);
  assign statRd = rdEn && (regSel == SEL_STAT);
  // Clear only honoured once the flag was observed set
  assign clrReq = statWr && !wrBit0 && armed;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txFlag <= 1'b0;
      armed  <= 1'b0;
    end else begin
      if (clrReq)         txFlag <= 1'b0;
      else if (belowTrig) txFlag <= 1'b1;

      if (clrReq)                    armed <= 1'b0;
      else if (statRd && txFlag)     armed <= 1'b1;
      else if (!txFlag && belowTrig) armed <= 1'b0;  // new set event
    end
  end
endmodule

// File: rtl/sctl_datapath.sv
module sctl_datapath
  import sctl_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int PRE_STEP   = 2,
  parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             standby,
  input  strobe_t          strb,
  input  logic [1:0]       regSel,
  input  logic [7:0]       wrData,
  input  logic [LVL_W-1:0] fifoLevel,
  input  logic             txFlag,
  output logic             belowTrig,
  output logic [7:0]       rdData,
  output logic             txIrq,
  output logic             txIntEn,
  output logic             rxIntEn,
  output logic             txEn,
  output logic             rxEn,
  output logic [1:0]       clkMode,
  output logic             baudTick,
  output logic [LVL_W-1:0] trigVal,
  output logic [1:0]       prescVal
);
  localparam int NUM_SEL = 4;
  localparam int PRE_W   = PRE_STEP * (NUM_SEL - 1);
  localparam logic [LVL_W-1:0] TRIG_RESET = LVL_W'(FIFO_DEPTH / 2);

  logic [5:0]       ctrlQ;    // {tie, rie, te, re, cke[1:0]}
  logic [1:0]       prescQ;
  logic [LVL_W-1:0] trigQ;
  logic [PRE_W-1:0] preCnt;
  logic [NUM_SEL-1:0] tickOpt;

  always_ff @(posedge clk) begin
    if (!rstN || standby)  ctrlQ <= '0;
    else if (strb.wrCtrl)  ctrlQ <= {wrData[7:4], wrData[1:0]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prescQ <= '0;
      trigQ  <= TRIG_RESET;
      preCnt <= '0;
    end else begin
      if (strb.wrPresc) prescQ <= wrData[1:0];
      if (strb.wrTrig)  trigQ  <= wrData[LVL_W-1:0];
      preCnt <= preCnt + 1'b1;
    end
  end

  for (genvar i = 0; i < NUM_SEL; i++) begin : g_tap
    if (i == 0) begin : g_full
      assign tickOpt[i] = 1'b1;
    end else begin : g_div
      assign tickOpt[i] = &preCnt[i*PRE_STEP-1:0];
    end
  end

  assign baudTick  = tickOpt[prescQ];
  assign belowTrig = fifoLevel < trigQ;
  assign {txIntEn, rxIntEn, txEn, rxEn, clkMode} = ctrlQ;
  assign txIrq     = txFlag && txIntEn;
  assign trigVal   = trigQ;
  assign prescVal  = prescQ;

  always_comb begin
    unique case (regSel)
      SEL_CTRL:  rdData = {ctrlQ[5:2], 2'b00, ctrlQ[1:0]};
      SEL_PRESC: rdData = {6'b0, prescQ};
      SEL_STAT:  rdData = {7'b0, txFlag};
      default:   rdData = 8'(trigQ);
    endcase
  end
endmodule

// File: rtl/sctl_top.sv
module sctl_top
  import sctl_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int PRE_STEP   = 2,
  parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             standby,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic [1:0]       regSel,
  input  logic [7:0]       wrData,
  output logic [7:0]       rdData,
  input  logic [LVL_W-1:0] fifoLevel,
  output logic             txIrq,
  output logic             txIntEn,
  output logic             rxIntEn,
  output logic             txEn,
  output logic             rxEn,
  output logic [1:0]       clkMode,
  output logic             baudTick,
  output logic             txEmptyFlag
);
  strobe_t          strb;
  logic             belowTrig;
  logic [LVL_W-1:0] trigVal;
  logic [1:0]       prescVal;

  sctl_control u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .regSel(regSel),
    .wrBit0(wrData[0]), .belowTrig(belowTrig), .strb(strb),
    .txFlag(txEmptyFlag)
  );

  sctl_datapath #(.FIFO_DEPTH(FIFO_DEPTH), .PRE_STEP(PRE_STEP), .LVL_W(LVL_W)) u_dp (
    .clk(clk), .rstN(rstN), .standby(standby), .strb(strb), .regSel(regSel),
    .wrData(wrData), .fifoLevel(fifoLevel), .txFlag(txEmptyFlag),
    .belowTrig(belowTrig), .rdData(rdData), .txIrq(txIrq),
    .txIntEn(txIntEn), .rxIntEn(rxIntEn), .txEn(txEn), .rxEn(rxEn),
    .clkMode(clkMode), .baudTick(baudTick), .trigVal(trigVal),
    .prescVal(prescVal)
  );
endmodule

// File: rtl/sctl_checker.sv
module sctl_checker #(
  parameter int LVL_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             standby,
  input logic             wrEn,
  input logic [1:0]       regSel,
  input logic [7:0]       wrData,
  input logic [7:0]       rdData,
  input logic [LVL_W-1:0] fifoLevel,
  input logic             txIrq,
  input logic             txIntEn,
  input logic             rxIntEn,
  input logic             txEn,
  input logic             rxEn,
  input logic [1:0]       clkMode,
  input logic             baudTick,
  input logic             txEmptyFlag,
  input logic [LVL_W-1:0] trigVal,
  input logic [1:0]       prescVal
);
  logic zeroWr;
  assign zeroWr = wrEn && (regSel == 2'd2) && !wrData[0];

  AST_STBY_RESET: assert property (@(posedge clk) disable iff (!rstN)
    standby |=> (!txIntEn && !rxIntEn && !txEn && !rxEn && clkMode == 2'b00)); // R3
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rstN)
    ((fifoLevel < trigVal) && !zeroWr) |=> txEmptyFlag); // R4
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (txEmptyFlag && !zeroWr) |=> txEmptyFlag); // R6
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    txIrq == (txEmptyFlag && txIntEn)); // R5
  AST_TICK_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (prescVal == 2'b00) |-> baudTick); // R1
  AST_TICK_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (baudTick && prescVal != 2'b00) |=> (!baudTick || prescVal == 2'b00)); // R1
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regSel == 2'd0) |-> (rdData[3:2] == 2'b00)); // R8
endmodule

bind sctl_top sctl_checker #(.LVL_W(LVL_W)) u_chk (
  .clk(clk), .rstN(rstN), .standby(standby), .wrEn(wrEn), .regSel(regSel),
  .wrData(wrData), .rdData(rdData), .fifoLevel(fifoLevel), .txIrq(txIrq),
  .txIntEn(txIntEn), .rxIntEn(rxIntEn), .txEn(txEn), .rxEn(rxEn),
  .clkMode(clkMode), .baudTick(baudTick), .txEmptyFlag(txEmptyFlag),
  .trigVal(trigVal), .prescVal(prescVal)
);

// File: tb/tb_sctl_top.sv
module tb_sctl_top;
  localparam int DEPTH = 16;
  localparam int LW    = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rstN, standby, wrEn, rdEn;
  logic [1:0] regSel;
  logic [7:0] wrData, rdData;
  logic [LW-1:0] fifoLevel;
  logic txIrq, txIntEn, rxIntEn, txEn, rxEn, baudTick, txEmptyFlag;
  logic [1:0] clkMode;

  int nChk = 0;
  int nFail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  sctl_top #(.FIFO_DEPTH(DEPTH)) dut (
    .clk(clk), .rstN(rstN), .standby(standby), .wrEn(wrEn), .rdEn(rdEn),
    .regSel(regSel), .wrData(wrData), .rdData(rdData), .fifoLevel(fifoLevel),
    .txIrq(txIrq), .txIntEn(txIntEn), .rxIntEn(rxIntEn), .txEn(txEn),
    .rxEn(rxEn), .clkMode(clkMode), .baudTick(baudTick),
    .txEmptyFlag(txEmptyFlag)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Called at a negedge; returns at the negedge after the write edge
  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    wrEn = 1'b1; regSel = s; wrData = d;
    @(posedge clk); @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [7:0] v);
    rdEn = 1'b1; regSel = s;
    #1 v = rdData;
    @(posedge clk); @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic flushFlag();
    logic [7:0] v;
    fifoLevel = LW'(DEPTH);
    rd(2'd2, v);
    wr(2'd2, 8'h00);
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int ticks;
    rstN = 1'b0; standby = 1'b0; wrEn = 1'b0; rdEn = 1'b0;
    regSel = 2'd0; wrData = 8'h00; fifoLevel = LW'(DEPTH);
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // Reset state
    rd(2'd0, v); check(v == 8'h00, "R2 ctrl reset", v, 0);
    rd(2'd1, v); check(v == 8'h00, "R1 presc reset", v, 0);
    rd(2'd2, v); check(v == 8'h00, "R4 flag reset", v, 0);
    rd(2'd3, v); check(v == 8'(DEPTH/2), "R9 trig reset", v, DEPTH/2);
    check(baudTick == 1'b1, "R1 tick at code 00", baudTick, 1);

    // Control register exhaustive sweep, reserved bits
    for (int d = 0; d < 256; d++) begin
      wr(2'd0, 8'(d));
      rd(2'd0, v);
      check(v == (8'(d) & 8'hF3), "R8 reserved read zero", v, d & 8'hF3);
      check({txIntEn, rxIntEn, txEn, rxEn, clkMode} == {d[7:4], d[1:0]},
            "R2 field pins", {txIntEn, rxIntEn, txEn, rxEn, clkMode},
            {d[7:4], d[1:0]});
    end

    // Standby
    wr(2'd0, 8'hF3);
    standby = 1'b1;
    @(posedge clk); @(negedge clk);
    rd(2'd0, v); check(v == 8'h00, "R3 standby clears", v, 0);
    wr(2'd0, 8'hFF);
    rd(2'd0, v); check(v == 8'h00, "R3 write blocked in standby", v, 0);
    standby = 1'b0;
    wr(2'd0, 8'h00);

    // Trigger x level sweep with interrupt enable alternating
    for (int t = 0; t <= DEPTH; t++) begin
      for (int l = 0; l <= DEPTH; l++) begin
        bit tie;
        bit expF;
        tie = 1'((t + l) & 1);
        expF = (l < t);
        flushFlag();
        check(txEmptyFlag == 1'b0, "R6 flag cleared after read", txEmptyFlag, 0);
        wr(2'd3, 8'(t));
        wr(2'd0, {tie, 7'b0});
        fifoLevel = LW'(l);
        @(posedge clk); @(negedge clk);
        check(txEmptyFlag == expF, "R4 flag vs trigger", txEmptyFlag, expF);
        check(txIrq == (expF && tie), "R5 irq gating", txIrq, expF && tie);
      end
      rd(2'd3, v); check(v == 8'(t), "R9 trig readback", v, t);
    end

    // Clear handshake
    wr(2'd3, 8'd8);
    wr(2'd0, 8'h80);
    fifoLevel = '0;
    @(posedge clk); @(negedge clk);
    wr(2'd2, 8'h00);
    check(txEmptyFlag == 1'b1, "R6 unarmed clear ignored", txEmptyFlag, 1);
    rd(2'd2, v); check(v == 8'h01, "R6 flag reads 1", v, 1);
    wr(2'd2, 8'h01);
    check(txEmptyFlag == 1'b1, "R6 write 1 no effect", txEmptyFlag, 1);
    wr(2'd2, 8'h00);
    check(txEmptyFlag == 1'b0, "R7 cleared for one cycle", txEmptyFlag, 0);
    @(negedge clk);
    check(txEmptyFlag == 1'b1, "R7 reset next cycle", txEmptyFlag, 1);
    check(txIrq == 1'b1, "R5 irq reasserts", txIrq, 1);
    wr(2'd2, 8'h00);
    check(txEmptyFlag == 1'b1, "R7 new set needs read", txEmptyFlag, 1);
    wr(2'd0, 8'h00);
    check(txIrq == 1'b0, "R5 enable off drops irq", txIrq, 0);
    rd(2'd2, v);
    fifoLevel = LW'(DEPTH);
    wr(2'd2, 8'h00);
    @(negedge clk);
    check(txEmptyFlag == 1'b0, "R6 armed clear with full fifo", txEmptyFlag, 0);

    // Prescaler rates over windows of 256 cycles
    for (int s = 0; s < 4; s++) begin
      wr(2'd1, 8'(s));
      rd(2'd1, v); check(v == 8'(s), "R1 presc readback", v, s);
      ticks = 0;
      for (int c = 0; c < 256; c++) begin
        #1 if (baudTick) ticks++;
        @(negedge clk);
      end
      check(ticks == (256 >> (2 * s)), "R1 tick rate", ticks, 256 >> (2 * s));
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule